// File: doc/BRIEF.md
# Priority Pin Crossbar Decoder

This block places a fixed, priority-ordered set of peripheral signals onto a bank of 25 port pins. Software-facing logic supplies one enable bit per peripheral function and one skip bit per pin. The decoder walks the signals in priority order and gives each enabled signal the lowest-numbered pin that is neither skipped nor already taken. The serial UART is an exception: it always sits on pins 4 and 5 and takes no part in that search. A pin that nothing claims stays general-purpose I/O and is driven from the port latch.

The assignment is held in registers and follows the configuration one clock later. A valid flag shows when the registered map matches the present enable and skip inputs. Pin drive, pin output-enable and the return path from the pins to the peripheral inputs are combinational, and they are taken from the registered map. If the search runs out of free pins, every signal left over stays unconnected and an overflow flag is raised.

Signals in priority order, each with its source code (code = signal index + 1, and code 0 = GPIO): function 0 UART (codes 1–2), function 1 SPI (codes 3–6), function 2 two-wire bus (codes 7–8), function 3 comparator 0 output (code 9), function 4 comparator 1 output (code 10), function 5 PWM (codes 11–14), function 6 timer clock input (code 15).

Top module: `xbar_top`

## Requirements
- R1: When function 0 is enabled, pin 4 reports code 1 and pin 5 reports code 2, whatever the skip bits are; when it is disabled those pins are free for the search.
- R2: Every other enabled signal, taken in ascending code order, gets the lowest-numbered pin that is not skipped and not yet taken, and that pin reports the signal's code.
- R3: A pin whose skip bit is set never receives a code other than 0, except pins 4 and 5 while function 0 is enabled.
- R4: When an enabled signal finds no free pin, it is left unconnected (no pin reports its code) and overflow_o is 1; otherwise overflow_o is 0.
- R5: A pin reporting code 0 drives gpio_do_i and gpio_oe_i of that pin on pin_do_o and pin_oe_o.
- R6: A pin reporting code c > 0 drives sig_do_i[c-1] and sig_oe_i[c-1].
- R7: sig_di_o[s] equals pin_di_i of the pin that reports code s+1, and is 0 when no pin reports it.
- R8: The map and overflow_o change only at the first rising clock edge after a configuration change. valid_o is 0 from the change until that edge, and 1 while the configuration stays stable afterwards.
- R9: While rst_ni is low, every pin reports code 0, and overflow_o and valid_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| func_en_i | input | 7 | Enable bit per peripheral function |
| pin_skip_i | input | 25 | Skip bit per pin |
| sig_do_i | input | 15 | Output value per peripheral signal |
| sig_oe_i | input | 15 | Output enable per peripheral signal |
| sig_di_o | output | 15 | Pin value returned to each peripheral signal |
| gpio_do_i | input | 25 | Port latch value per pin |
| gpio_oe_i | input | 25 | GPIO output enable per pin |
| pin_di_i | input | 25 | Value read from each pin |
| pin_do_o | output | 25 | Routed drive value per pin |
| pin_oe_o | output | 25 | Routed output enable per pin |
| pin_src_o | output | 100 | 4-bit source code per pin, pin p at bits [4p+3:4p] |
| overflow_o | output | 1 | An enabled signal found no free pin |
| valid_o | output | 1 | Registered map matches the present configuration |

## Verification
A new enable or skip pattern is driven on a falling edge. One time unit later the bench expects valid_o low and the previous map still on pin_src_o. At the next falling edge, after exactly one rising edge, it expects the new map, the overflow flag and valid_o high. The routing outputs carry no register: the bench changes the data inputs away from the clock edge and checks pin_do_o, pin_oe_o and sig_di_o one time unit later, against the map it expects for that configuration. Both the reference walk of the priority list and the expected routing are computed in the bench, for directed and random enable and skip patterns.

// File: rtl/xbar_pkg.sv
`timescale 1ns/1ps
package xbar_pkg;
  localparam int NUM_FUNCS = 7;
  localparam int NUM_PINS  = 25;
  localparam int FUNC_SIGS [NUM_FUNCS] = '{2, 4, 2, 1, 1, 4, 1};
  localparam int UART_FUNC = 0;
  localparam int UART_PIN  = 4;

  function automatic int count_sigs();
    int t;
    t = 0;
    for (int i = 0; i < NUM_FUNCS; i++) t += FUNC_SIGS[i];
    return t;
  endfunction

  localparam int NUM_SIGS = count_sigs();
  localparam int SRC_W    = $clog2(NUM_SIGS + 1);

  // owning function of signal s (signals are numbered in priority order)
  function automatic int sig_func(int s);
    int base;
    base = 0;
    for (int f = 0; f < NUM_FUNCS; f++) begin
      if (s >= base && s < base + FUNC_SIGS[f]) return f;
      base += FUNC_SIGS[f];
    end
    return NUM_FUNCS - 1;
  endfunction
endpackage

// File: rtl/xbar_alloc.sv
`timescale 1ns/1ps
module xbar_alloc
  import xbar_pkg::*;
#(
  parameter int NP = NUM_PINS,
  parameter int NF = NUM_FUNCS,
  parameter int NS = NUM_SIGS,
  parameter int SW = SRC_W,
  parameter int UP = UART_PIN
) (
  input  logic [NF-1:0]         en_i,
  input  logic [NP-1:0]         skip_i,
  output logic [NP-1:0][SW-1:0] src_o,
  output logic                  ovf_o
);
  localparam int NU = FUNC_SIGS[UART_FUNC];

  logic [NP-1:0] taken;
  logic          found;

  always_comb begin
    taken = skip_i;
    src_o = '0;
    ovf_o = 1'b0;
    found = 1'b0;
    // top-priority function sits on fixed pins, overriding skip
    if (en_i[UART_FUNC]) begin
      for (int u = 0; u < NU; u++) begin
        src_o[UP+u] = SW'(u + 1);
        taken[UP+u] = 1'b1;
      end
    end
    for (int s = NU; s < NS; s++) begin
      if (en_i[sig_func(s)]) begin
        found = 1'b0;
        for (int p = 0; p < NP; p++) begin
          if (!found && !taken[p]) begin
            src_o[p] = SW'(s + 1);
            taken[p] = 1'b1;
            found    = 1'b1;
          end
        end
        if (!found) ovf_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/xbar_pin_mux.sv
`timescale 1ns/1ps
module xbar_pin_mux #(
  parameter int NP = 25,
  parameter int NS = 15,
  parameter int SW = 4
) (
  input  logic [NP-1:0][SW-1:0] map_i,
  input  logic [NS-1:0]         sig_do_i,
  input  logic [NS-1:0]         sig_oe_i,
  input  logic [NP-1:0]         gpio_do_i,
  input  logic [NP-1:0]         gpio_oe_i,
  output logic [NP-1:0]         pin_do_o,
  output logic [NP-1:0]         pin_oe_o
);
  for (genvar p = 0; p < NP; p++) begin : g_pin
    logic [SW-1:0] idx;
    logic          sel_do, sel_oe;
    assign idx = map_i[p] - SW'(1);
    always_comb begin
      sel_do = 1'b0;
      sel_oe = 1'b0;
      for (int s = 0; s < NS; s++) begin
        if (idx == SW'(s)) begin
          sel_do = sig_do_i[s];
          sel_oe = sig_oe_i[s];
        end
      end
    end
    assign pin_do_o[p] = (map_i[p] == '0) ? gpio_do_i[p] : sel_do;
    assign pin_oe_o[p] = (map_i[p] == '0) ? gpio_oe_i[p] : sel_oe;
  end
endmodule

// File: rtl/xbar_sig_return.sv
`timescale 1ns/1ps
module xbar_sig_return #(
  parameter int NP = 25,
  parameter int NS = 15,
  parameter int SW = 4
) (
  input  logic [NP-1:0][SW-1:0] map_i,
  input  logic [NP-1:0]         pin_di_i,
  output logic [NS-1:0]         sig_di_o
);
  for (genvar s = 0; s < NS; s++) begin : g_sig
    always_comb begin
      sig_di_o[s] = 1'b0;
      for (int p = 0; p < NP; p++) begin
        if (map_i[p] == SW'(s + 1)) sig_di_o[s] = pin_di_i[p];
      end
    end
  end
endmodule

// File: rtl/xbar_top.sv
`timescale 1ns/1ps
module xbar_top
  import xbar_pkg::*;
#(
  parameter int NP = NUM_PINS,
  parameter int NF = NUM_FUNCS,
  parameter int NS = NUM_SIGS,
  parameter int SW = SRC_W,
  parameter int UP = UART_PIN
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NF-1:0]    func_en_i,
  input  logic [NP-1:0]    pin_skip_i,
  input  logic [NS-1:0]    sig_do_i,
  input  logic [NS-1:0]    sig_oe_i,
  output logic [NS-1:0]    sig_di_o,
  input  logic [NP-1:0]    gpio_do_i,
  input  logic [NP-1:0]    gpio_oe_i,
  input  logic [NP-1:0]    pin_di_i,
  output logic [NP-1:0]    pin_do_o,
  output logic [NP-1:0]    pin_oe_o,
  output logic [NP*SW-1:0] pin_src_o,
  output logic             overflow_o,
  output logic             valid_o
);
  localparam int CFG_W = NF + NP;

  logic [NP-1:0][SW-1:0] map_d, map_q;
  logic                  ovf_d, ovf_q;
  logic [CFG_W-1:0]      cfg_q;
  logic                  init_q;

  xbar_alloc #(.NP(NP), .NF(NF), .NS(NS), .SW(SW), .UP(UP)) u_alloc (
    .en_i   (func_en_i),
    .skip_i (pin_skip_i),
    .src_o  (map_d),
    .ovf_o  (ovf_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map_q  <= '0;
      ovf_q  <= 1'b0;
      cfg_q  <= '0;
      init_q <= 1'b0;
    end else begin
      map_q  <= map_d;
      ovf_q  <= ovf_d;
      cfg_q  <= {func_en_i, pin_skip_i};
      init_q <= 1'b1;
    end
  end

  xbar_pin_mux #(.NP(NP), .NS(NS), .SW(SW)) u_mux (
    .map_i     (map_q),
    .sig_do_i  (sig_do_i),
    .sig_oe_i  (sig_oe_i),
    .gpio_do_i (gpio_do_i),
    .gpio_oe_i (gpio_oe_i),
    .pin_do_o  (pin_do_o),
    .pin_oe_o  (pin_oe_o)
  );

  xbar_sig_return #(.NP(NP), .NS(NS), .SW(SW)) u_ret (
    .map_i    (map_q),
    .pin_di_i (pin_di_i),
    .sig_di_o (sig_di_o)
  );

  assign pin_src_o  = map_q;
  assign overflow_o = ovf_q;
  assign valid_o    = init_q && (cfg_q == {func_en_i, pin_skip_i});
endmodule

// File: rtl/xbar_chk.sv
`timescale 1ns/1ps
module xbar_chk #(
  parameter int NP = 25,
  parameter int NF = 7,
  parameter int NS = 15,
  parameter int SW = 4,
  parameter int UP = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NF-1:0]    func_en_i,
  input logic [NP-1:0]    pin_skip_i,
  input logic [NS-1:0]    sig_do_i,
  input logic [NS-1:0]    sig_oe_i,
  input logic [NP-1:0]    gpio_do_i,
  input logic [NP-1:0]    gpio_oe_i,
  input logic [NP-1:0]    pin_do_o,
  input logic [NP-1:0]    pin_oe_o,
  input logic [NP*SW-1:0] pin_src_o,
  input logic             overflow_o,
  input logic             valid_o
);
  assert_uart_fixed_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && func_en_i[0]) |->
      (pin_src_o[UP*SW +: SW] == SW'(1) && pin_src_o[(UP+1)*SW +: SW] == SW'(2)));

  assert_valid_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $stable({func_en_i, pin_skip_i}));

  for (genvar p = 0; p < NP; p++) begin : g_p
    localparam bit IS_U = (p == UP) || (p == UP + 1);
    logic [SW-1:0] src;
    logic [SW-1:0] idx;
    assign src = pin_src_o[p*SW +: SW];
    assign idx = src - SW'(1);

    assert_skip_gpio_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && pin_skip_i[p] && !(IS_U && func_en_i[0])) |-> (src == '0));

    assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && overflow_o && !pin_skip_i[p]) |-> (src != '0));

    assert_gpio_drive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (src == '0) |-> (pin_do_o[p] == gpio_do_i[p] && pin_oe_o[p] == gpio_oe_i[p]));

    assert_sig_drive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (src != '0 && int'(src) <= NS) |->
        (pin_do_o[p] == sig_do_i[idx] && pin_oe_o[p] == sig_oe_i[idx]));
  end
endmodule

bind xbar_top xbar_chk #(.NP(NP), .NF(NF), .NS(NS), .SW(SW), .UP(UP)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .func_en_i  (func_en_i),
  .pin_skip_i (pin_skip_i),
  .sig_do_i   (sig_do_i),
  .sig_oe_i   (sig_oe_i),
  .gpio_do_i  (gpio_do_i),
  .gpio_oe_i  (gpio_oe_i),
  .pin_do_o   (pin_do_o),
  .pin_oe_o   (pin_oe_o),
  .pin_src_o  (pin_src_o),
  .overflow_o (overflow_o),
  .valid_o    (valid_o)
);

// File: tb/test_xbar_top.sv
`timescale 1ns/1ps
module test_xbar_top;
  localparam int NP = 25;
  localparam int NF = 7;
  localparam int NS = 15;
  localparam int SW = 4;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [NF-1:0]    func_en_i = '1;
  logic [NP-1:0]    pin_skip_i = '0;
  logic [NS-1:0]    sig_do_i = '0, sig_oe_i = '0, sig_di_o;
  logic [NP-1:0]    gpio_do_i = '0, gpio_oe_i = '0, pin_di_i = '0;
  logic [NP-1:0]    pin_do_o, pin_oe_o;
  logic [NP*SW-1:0] pin_src_o;
  logic             overflow_o, valid_o;

  xbar_top i_xbar_top (.*);

  always #10 clk_i = ~clk_i;  // 50 MHz

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int exp_src [NP];
  bit exp_ovf;
  int owner [$];
  int counts [NF] = '{2, 4, 2, 1, 1, 4, 1};

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference: walk priority list with a queue of free pins
  function automatic void model(logic [NF-1:0] en, logic [NP-1:0] sk);
    int freeq [$];
    exp_ovf = 0;
    for (int p = 0; p < NP; p++) begin
      exp_src[p] = 0;
      if (en[0] && (p == 4 || p == 5)) exp_src[p] = p - 3;
      else if (!sk[p]) freeq.push_back(p);
    end
    for (int s = 2; s < NS; s++) begin
      if (en[owner[s]]) begin
        if (freeq.size() > 0) exp_src[freeq.pop_front()] = s + 1;
        else exp_ovf = 1;
      end
    end
  endfunction

  function automatic logic [NP*SW-1:0] exp_vec();
    logic [NP*SW-1:0] v;
    for (int p = 0; p < NP; p++) v[p*SW +: SW] = SW'(exp_src[p]);
    return v;
  endfunction

  task automatic check_map();
    for (int p = 0; p < NP; p++) begin
      int act;
      string req;
      act = int'(pin_src_o[p*SW +: SW]);
      if (func_en_i[0] && (p == 4 || p == 5)) req = "R1";
      else if (pin_skip_i[p]) req = "R3";
      else req = "R2";
      chk(act == exp_src[p], req, $sformatf("pin %0d code", p), act, exp_src[p]);
    end
    chk(overflow_o == exp_ovf, "R4", "overflow", overflow_o, exp_ovf);
  endtask

  task automatic check_route();
    logic [NP-1:0] edo, eoe;
    logic [NS-1:0] edi;
    sig_do_i = NS'($urandom); sig_oe_i = NS'($urandom);
    gpio_do_i = NP'($urandom); gpio_oe_i = NP'($urandom); pin_di_i = NP'($urandom);
    #1;
    edi = '0;
    for (int p = 0; p < NP; p++) begin
      if (exp_src[p] == 0) begin edo[p] = gpio_do_i[p]; eoe[p] = gpio_oe_i[p]; end
      else begin
        edo[p] = sig_do_i[exp_src[p]-1]; eoe[p] = sig_oe_i[exp_src[p]-1];
        edi[exp_src[p]-1] = pin_di_i[p];
      end
    end
    chk({pin_do_o, pin_oe_o} == {edo, eoe}, "R5/R6", "pin drive", {pin_do_o, pin_oe_o}, {edo, eoe});
    chk(sig_di_o == edi, "R7", "signal return", sig_di_o, edi);
  endtask

  task automatic apply(logic [NF-1:0] en, logic [NP-1:0] sk);
    bit changed;
    @(negedge clk_i);
    changed = ({en, sk} != {func_en_i, pin_skip_i});
    func_en_i = en; pin_skip_i = sk;
    #1;
    if (changed) begin
      chk(valid_o == 0, "R8", "valid after change", valid_o, 0);
      chk(pin_src_o == exp_vec(), "R8", "map held before edge", pin_src_o, exp_vec());
    end else chk(valid_o == 1, "R8", "valid on same config", valid_o, 1);
    @(negedge clk_i);
    model(en, sk);
    check_map();
    chk(valid_o == 1, "R8", "valid after edge", valid_o, 1);
    check_route();
  endtask

  initial begin
    for (int f = 0; f < NF; f++) for (int k = 0; k < counts[f]; k++) owner.push_back(f);
    repeat (3) @(negedge clk_i);
    // R9: reset holds despite enables being set
    chk(pin_src_o == '0, "R9", "codes in reset", pin_src_o, 0);
    chk(overflow_o == 0, "R9", "overflow in reset", overflow_o, 0);
    chk(valid_o == 0, "R9", "valid in reset", valid_o, 0);
    rst_ni = 1'b1;
    model('1, '0);
    apply('0, '0);
    apply(7'h01, 25'h30);                 // UART over its own skipped pins
    apply(7'h01, 25'h30);                 // unchanged config
    apply(7'h02, 25'h07);                 // SPI alone, lands on 3..6
    apply('1, '0);
    apply('1, 25'h1ff_fff0);              // few free pins: overflow
    apply(7'h7e, 25'h1ff_ffcf);           // UART off: pins 4,5 free
    apply('1, '1);
    for (int i = 0; i < 300; i++) begin
      logic [NP-1:0] sk;
      sk = NP'($urandom) & NP'($urandom);
      if (i % 5 == 0) sk = NP'($urandom) | NP'($urandom);
      apply(NF'($urandom), sk);
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule